// File: doc/BRIEF.md
# Tiled Depth Rectangle Copier

This block moves a rectangle of 32-bit depth/stencil pixels between a bank-swizzled tiled surface and a packed linear buffer. A start pulse captures the whole setup: the direction (detile copies tiled to linear, retile copies linear to tiled), a write-back request, an optional vertical flip, the surface pitch in bytes and height in rows, the rectangle origin and size, and the two base byte addresses. The block then walks the rectangle one pixel at a time. For each pixel it reads one word and writes that same word back out.

Memory traffic uses two plain ports. The read port has a valid/ready request channel and a response strobe. The write port has a valid/ready channel that carries address and data together. Only one read is ever in flight. A pixel's write is raised only after its read data has come back, so a stall on either port freezes the walk.

Top module: `tile_rect_copy`

## Requirements
- R1: Configuration is captured only by a start pulse seen while the block is idle. Input changes, and further start pulses, while busy have no effect on the running copy.
- R2: Each pixel of the rectangle is visited once, column fastest and then row by row from the first row. Each visit makes exactly one word read and one word write, and the write data equals that pixel's read data.
- R3: Tiled byte offset of surface pixel (x, y): b = y[10:4] * (pitch/128) + x/32; offset bits 31:12 = b/2, bits 10:9 = y[3:2], bit 8 = x[2], bits 7:6 = x[4:3], bit 5 = y[1], bit 4 = x[1], bit 3 = y[0], bit 2 = x[0], bits 1:0 = 0. Only y bits 10:0 take part.
- R4: Tiled offset bit 11 is b[0] when pitch/128 is odd, and b[0] XOR y[4] when pitch/128 is even.
- R5: With flip set, the surface row for rectangle row r is (height - 1) - (origin_y + r). Without flip it is origin_y + r. The surface column is origin_x + c.
- R6: Linear byte address of rectangle pixel (c, r) = linear base + (r * width + c) * 4. Tiled address = tiled base + tiled offset.
- R7: In detile mode (retile = 0), reads use tiled addresses and writes use linear addresses. In retile mode the two are swapped.
- R8: Retile without write-back completes with no read or write request.
- R9: A zero width or zero row count completes with no read or write request.
- R10: busy is high from the cycle after an accepted start until the last write is accepted. done is a one-cycle pulse in the cycle after the last write acceptance, or in the cycle after start for a copy that completes at once. done is never high together with busy.
- R11: At most one access is requested at a time. A write is raised only after read data has returned. A stalled request holds its address (and data) stable.
- R12: After reset, busy, done, rd_valid and wr_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a copy and captures the configuration when idle |
| cfg_retile | input | 1 | 0 = tiled to linear, 1 = linear to tiled |
| cfg_writeback | input | 1 | Write-back requested; retile runs only when set |
| cfg_flip | input | 1 | Vertical flip of the surface row |
| cfg_tiled_base | input | ADDR_W | Byte base of the tiled surface |
| cfg_linear_base | input | ADDR_W | Byte base of the linear buffer |
| cfg_pitch | input | PITCH_W | Surface pitch in bytes |
| cfg_height | input | DIM_W | Surface height in rows |
| cfg_org_x | input | DIM_W | Rectangle origin column |
| cfg_org_y | input | DIM_W | Rectangle origin row |
| cfg_width | input | DIM_W | Rectangle width in pixels |
| cfg_rows | input | DIM_W | Rectangle height in rows |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read byte address |
| rd_rvalid | input | 1 | Read data returned |
| rd_rdata | input | DATA_W | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | DATA_W | Write data |

## Verification
Assertions watch the port discipline on every cycle: requests that hold their address under stall, the single-access rule, writes that follow a returned read, the one-cycle done pulse that never overlaps busy, and walk counters that stay in range and hold when no transfer completes. The bench scenarios show what no cycle-local property can: the full address sequence for both pitch parities, band crossings, y values above 2047, flip, both directions, the cases that complete at once, and the fact that input changes during a copy are ignored.

// File: rtl/tile_copy_pkg.sv
package tile_copy_pkg;

  localparam int CALC_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_WAIT = 2'd2,
    ST_WR      = 2'd3
  } copy_state_e;

  // Byte offset of pixel (x, y) in the swizzled tiled surface.
  function automatic logic [CALC_W-1:0] tiled_offset(
    input logic [CALC_W-1:0] x,
    input logic [CALC_W-1:0] y,
    input logic [CALC_W-1:0] pitch_bytes
  );
    logic [CALC_W-1:0] tiles_per_row;
    logic [CALC_W-1:0] band;
    logic [CALC_W-1:0] blk;
    logic [CALC_W-1:0] off;
    logic              parity;
    tiles_per_row = pitch_bytes >> 7;
    band          = CALC_W'(y[10:4]);
    blk           = band * tiles_per_row + (x >> 5);
    parity        = tiles_per_row[0] ? blk[0] : (blk[0] ^ y[4]);
    off           = (blk >> 1) << 12;
    off[11]       = parity;
    off[10:9]     = y[3:2];
    off[8]        = x[2];
    off[7:6]      = x[4:3];
    off[5]        = y[1];
    off[4]        = x[1];
    off[3]        = y[0];
    off[2]        = x[0];
    off[1:0]      = 2'b00;
    return off;
  endfunction

  // Byte offset of rectangle pixel (col, row) in the packed buffer.
  function automatic logic [CALC_W-1:0] linear_offset(
    input logic [CALC_W-1:0] col,
    input logic [CALC_W-1:0] row,
    input logic [CALC_W-1:0] width
  );
    return (row * width + col) << 2;
  endfunction

endpackage

// File: rtl/rect_walker.sv
module rect_walker #(
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] rows,
  output logic [DIM_W-1:0] col,
  output logic [DIM_W-1:0] row,
  output logic             last
);

  logic row_end;

  assign row_end = (col == width - DIM_W'(1));
  assign last    = row_end && (row == rows - DIM_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (load) begin
      col <= '0;
      row <= '0;
    end else if (step) begin
      if (row_end) begin
        col <= '0;
        row <= row + DIM_W'(1);
      end else begin
        col <= col + DIM_W'(1);
      end
    end
  end

  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> ($stable(col) && $stable(row))); // R11

endmodule

// File: rtl/copy_fsm.sv
module copy_fsm
  import tile_copy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic skip,
  input  logic last,
  input  logic rd_ready,
  input  logic rd_rvalid,
  input  logic wr_ready,
  output logic load,
  output logic step,
  output logic capture,
  output logic rd_valid,
  output logic wr_valid,
  output logic busy,
  output logic done
);

  copy_state_e state_q, state_d;
  logic        done_d;

  assign rd_valid = (state_q == ST_RD_REQ);
  assign wr_valid = (state_q == ST_WR);
  assign busy     = (state_q != ST_IDLE);
  assign load     = (state_q == ST_IDLE) && start && !skip;
  assign capture  = (state_q == ST_RD_WAIT) && rd_rvalid;
  assign step     = wr_valid && wr_ready;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (skip) done_d  = 1'b1;
          else      state_d = ST_RD_REQ;
        end
      end
      ST_RD_REQ:  if (rd_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (rd_rvalid) state_d = ST_WR;
      ST_WR: begin
        if (wr_ready) begin
          if (last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_RD_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

  AST_WR_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(rd_rvalid)); // R11

endmodule

// File: rtl/tile_rect_copy.sv
module tile_rect_copy
  import tile_copy_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int DIM_W   = 12,
  parameter int PITCH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cfg_retile,
  input  logic               cfg_writeback,
  input  logic               cfg_flip,
  input  logic [ADDR_W-1:0]  cfg_tiled_base,
  input  logic [ADDR_W-1:0]  cfg_linear_base,
  input  logic [PITCH_W-1:0] cfg_pitch,
  input  logic [DIM_W-1:0]   cfg_height,
  input  logic [DIM_W-1:0]   cfg_org_x,
  input  logic [DIM_W-1:0]   cfg_org_y,
  input  logic [DIM_W-1:0]   cfg_width,
  input  logic [DIM_W-1:0]   cfg_rows,
  output logic               busy,
  output logic               done,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic               rd_rvalid,
  input  logic [DATA_W-1:0]  rd_rdata,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data
);

  // Latched setup
  logic               retile_q, flip_q;
  logic [ADDR_W-1:0]  tbase_q, lbase_q;
  logic [PITCH_W-1:0] pitch_q;
  logic [DIM_W-1:0]   height_q, ox_q, oy_q, width_q, rows_q;
  logic [DATA_W-1:0]  data_q;

  // Events between the pieces
  logic             load, step, capture, last, skip;
  logic [DIM_W-1:0] col, row;
  logic [DIM_W-1:0] view_row, surf_row, surf_col;
  logic [ADDR_W-1:0] tiled_addr, linear_addr;

  assign skip = (cfg_width == '0) || (cfg_rows == '0) || (cfg_retile && !cfg_writeback);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retile_q <= 1'b0;
      flip_q   <= 1'b0;
      tbase_q  <= '0;
      lbase_q  <= '0;
      pitch_q  <= '0;
      height_q <= '0;
      ox_q     <= '0;
      oy_q     <= '0;
      width_q  <= '0;
      rows_q   <= '0;
    end else if (load) begin
      retile_q <= cfg_retile;
      flip_q   <= cfg_flip;
      tbase_q  <= cfg_tiled_base;
      lbase_q  <= cfg_linear_base;
      pitch_q  <= cfg_pitch;
      height_q <= cfg_height;
      ox_q     <= cfg_org_x;
      oy_q     <= cfg_org_y;
      width_q  <= cfg_width;
      rows_q   <= cfg_rows;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (capture) data_q <= rd_rdata;
  end

  rect_walker #(.DIM_W(DIM_W)) walker_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .width (width_q),
    .rows  (rows_q),
    .col   (col),
    .row   (row),
    .last  (last)
  );

  copy_fsm fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .skip      (skip),
    .last      (last),
    .rd_ready  (rd_ready),
    .rd_rvalid (rd_rvalid),
    .wr_ready  (wr_ready),
    .load      (load),
    .step      (step),
    .capture   (capture),
    .rd_valid  (rd_valid),
    .wr_valid  (wr_valid),
    .busy      (busy),
    .done      (done)
  );

  // Coordinate mapping
  assign view_row = oy_q + row;
  assign surf_row = flip_q ? (height_q - DIM_W'(1) - view_row) : view_row;
  assign surf_col = ox_q + col;

  assign tiled_addr  = tbase_q + ADDR_W'(tiled_offset(CALC_W'(surf_col), CALC_W'(surf_row),
                                                      CALC_W'(pitch_q)));
  assign linear_addr = lbase_q + ADDR_W'(linear_offset(CALC_W'(col), CALC_W'(row),
                                                       CALC_W'(width_q)));

  assign rd_addr = retile_q ? linear_addr : tiled_addr;
  assign wr_addr = retile_q ? tiled_addr  : linear_addr;
  assign wr_data = data_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R11
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R11
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_WALK_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((col < width_q) && (row < rows_q))); // R2

endmodule

// File: tb/tile_rect_copy_tb_top.sv
module tile_rect_copy_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAXLOG     = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_retile = 1'b0, cfg_writeback = 1'b0, cfg_flip = 1'b0;
  logic [31:0] cfg_tiled_base = '0, cfg_linear_base = '0;
  logic [15:0] cfg_pitch = '0;
  logic [11:0] cfg_height = '0, cfg_org_x = '0, cfg_org_y = '0, cfg_width = '0, cfg_rows = '0;
  logic        busy, done, rd_valid, rd_ready, rd_rvalid, wr_valid, wr_ready;
  logic [31:0] rd_addr, rd_rdata, wr_addr, wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_rect_copy dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_retile(cfg_retile), .cfg_writeback(cfg_writeback), .cfg_flip(cfg_flip),
    .cfg_tiled_base(cfg_tiled_base), .cfg_linear_base(cfg_linear_base),
    .cfg_pitch(cfg_pitch), .cfg_height(cfg_height),
    .cfg_org_x(cfg_org_x), .cfg_org_y(cfg_org_y),
    .cfg_width(cfg_width), .cfg_rows(cfg_rows),
    .busy(busy), .done(done),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Memory model with optional back-pressure and longer latency
  logic       stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA7;
  logic       p1 = 1'b0, p2 = 1'b0;
  logic [31:0] a1 = '0, a2 = '0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h0000_9E37) ^ 32'h5A5A_0F0F;
  endfunction

  assign rd_ready  = stall_en ? lfsr[0] : 1'b1;
  assign wr_ready  = stall_en ? lfsr[3] : 1'b1;
  assign rd_rvalid = stall_en ? p2 : p1;
  assign rd_rdata  = mem_word(stall_en ? a2 : a1);

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    p1 <= rd_valid && rd_ready;
    a1 <= rd_addr;
    p2 <= p1;
    a2 <= a1;
  end

  // Traffic log
  int n_checks = 0, n_fail = 0;
  int cyc = 0, nrd = 0, nwr = 0, ndone = 0;
  int start_cyc = 0, last_wr_cyc = 0, done_cyc = 0;
  logic [31:0] rd_log [MAXLOG];
  logic [31:0] wa_log [MAXLOG];
  logic [31:0] wd_log [MAXLOG];

  always @(posedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      if (start && !busy) start_cyc = cyc;
      if (rd_valid && rd_ready) begin
        if (nrd < MAXLOG) rd_log[nrd] = rd_addr;
        nrd = nrd + 1;
      end
      if (wr_valid && wr_ready) begin
        if (nwr < MAXLOG) begin wa_log[nwr] = wr_addr; wd_log[nwr] = wr_data; end
        nwr = nwr + 1;
        last_wr_cyc = cyc;
      end
      if (done) begin ndone = ndone + 1; done_cyc = cyc; end
    end
  end

  // Snapshot of the setup the current run is expected to use
  int e_retile, e_wb, e_flip, e_tb, e_lb, e_pitch, e_hgt, e_ox, e_oy, e_w, e_h;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic int ref_tiled(input int x, input int y, input int pitch);
    int tpr, blk, sel, r;
    tpr = pitch / 128;
    blk = ((y / 16) % 128) * tpr + x / 32;
    if (tpr % 2 == 1) sel = blk % 2;
    else              sel = (blk % 2) ^ ((y / 16) % 2);
    r = (blk / 2) * 4096 + sel * 2048 + ((y / 4) % 4) * 512 + ((x / 4) % 2) * 256
      + ((x / 8) % 4) * 64 + ((y / 2) % 2) * 32 + ((x / 2) % 2) * 16 + (y % 2) * 8 + (x % 2) * 4;
    return r;
  endfunction

  task automatic set_cfg(input int retile, input int wb, input int flip, input int tb, input int lb,
                         input int pitch, input int hgt, input int ox, input int oy,
                         input int w, input int h);
    cfg_retile = retile[0]; cfg_writeback = wb[0]; cfg_flip = flip[0];
    cfg_tiled_base = tb; cfg_linear_base = lb; cfg_pitch = 16'(pitch);
    cfg_height = 12'(hgt); cfg_org_x = 12'(ox); cfg_org_y = 12'(oy);
    cfg_width = 12'(w); cfg_rows = 12'(h);
    e_retile = retile; e_wb = wb; e_flip = flip; e_tb = tb; e_lb = lb; e_pitch = pitch;
    e_hgt = hgt; e_ox = ox; e_oy = oy; e_w = w; e_h = h;
  endtask

  task automatic launch();
    @(negedge clk);
    nrd = 0; nwr = 0; ndone = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (ndone == 0 && t < 3000) begin @(negedge clk); t++; end
    if (ndone == 0) check(1'b0, req, "done timeout", 32'(t), 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input string req);
    int npix, sx, sy, t, l, er, ew;
    bit imm;
    imm  = (e_w == 0) || (e_h == 0) || (e_retile == 1 && e_wb == 0);
    npix = imm ? 0 : e_w * e_h;
    check(nrd == npix, req, "read count", 32'(nrd), 32'(npix));
    check(nwr == npix, req, "write count", 32'(nwr), 32'(npix));
    check(ndone == 1, "R10", "done pulses", 32'(ndone), 32'd1);
    if (npix == 0) check(done_cyc == start_cyc + 1, "R10", "done cycle (immediate)",
                         32'(done_cyc), 32'(start_cyc + 1));
    else           check(done_cyc == last_wr_cyc + 1, "R10", "done cycle",
                         32'(done_cyc), 32'(last_wr_cyc + 1));
    check(!busy, "R10", "busy after done", 32'(busy), 32'd0);
    for (int i = 0; i < npix && i < MAXLOG; i++) begin
      sx = e_ox + i % e_w;
      sy = e_flip ? (e_hgt - 1 - (e_oy + i / e_w)) : (e_oy + i / e_w);
      t  = e_tb + ref_tiled(sx, sy, e_pitch);
      l  = e_lb + ((i / e_w) * e_w + i % e_w) * 4;
      er = e_retile ? l : t;
      ew = e_retile ? t : l;
      check(rd_log[i] == 32'(er), req, $sformatf("read addr px %0d", i), rd_log[i], 32'(er));
      check(wa_log[i] == 32'(ew), req, $sformatf("write addr px %0d", i), wa_log[i], 32'(ew));
      check(wd_log[i] == mem_word(32'(er)), "R2", $sformatf("write data px %0d", i),
            wd_log[i], mem_word(32'(er)));
    end
  endtask

  // Scenarios
  task automatic t_reset();
    check(!busy && !done, "R12", "busy/done after reset", {30'd0, busy, done}, 32'd0);
    check(!rd_valid && !wr_valid, "R12", "requests after reset", {30'd0, rd_valid, wr_valid}, 32'd0);
  endtask

  task automatic t_detile_even_pitch();
    // R3 R4 R6 R7: even pitch/128, crosses x=32 and y=16 boundaries
    stall_en = 1'b0;
    set_cfg(0, 0, 0, 32'h0010_0000, 32'h0800_0000, 256, 64, 30, 14, 6, 4);
    launch(); wait_done("R4"); verify("R4");
  endtask

  task automatic t_detile_odd_flip_stall();
    // R5 R11 R4: odd pitch/128, flip, back-pressure on both ports
    stall_en = 1'b1;
    set_cfg(0, 0, 1, 32'h0020_0000, 32'h0900_0000, 384, 64, 60, 10, 5, 4);
    launch(); wait_done("R5"); verify("R5");
    stall_en = 1'b0;
  endtask

  task automatic t_retile_high_y();
    // R7 R3: linear to tiled, y above 2047 uses only its low 11 bits
    set_cfg(1, 1, 0, 32'h0030_0000, 32'h0A00_0000, 128, 4095, 3, 2060, 4, 3);
    launch(); wait_done("R7"); verify("R7");
  endtask

  task automatic t_retile_no_wb();
    set_cfg(1, 0, 0, 32'h0030_0000, 32'h0A00_0000, 256, 64, 0, 0, 4, 4);
    launch(); wait_done("R8"); verify("R8");
  endtask

  task automatic t_zero_size();
    set_cfg(0, 0, 0, 32'h0, 32'h1000, 256, 64, 0, 0, 0, 5);
    launch(); wait_done("R9"); verify("R9");
    set_cfg(0, 0, 0, 32'h0, 32'h1000, 256, 64, 0, 0, 5, 0);
    launch(); wait_done("R9"); verify("R9");
  endtask

  task automatic t_cfg_ignored_while_busy();
    // R1: setup captured at start; changes and extra starts while busy are ignored
    stall_en = 1'b1;
    set_cfg(0, 0, 0, 32'h0040_0000, 32'h0B00_0000, 512, 64, 8, 33, 3, 3);
    launch();
    cfg_width = 12'd9; cfg_rows = 12'd7; cfg_org_x = 12'd100; cfg_flip = 1'b1;
    cfg_retile = 1'b1; cfg_writeback = 1'b1; cfg_tiled_base = 32'hDEAD_0000;
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done("R1"); verify("R1");
    stall_en = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_detile_even_pitch();
    t_detile_odd_flip_stall();
    t_retile_high_y();
    t_retile_no_wb();
    t_zero_size();
    t_cfg_ignored_while_busy();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule